// File: doc/BRIEF.md
# Flash Command-Mode Responder

This block is the device side of a small parallel flash model. It watches write cycles on an asynchronous-style bus and treats them as commands. Depending on the commands it has seen, it answers reads in one of three modes: normal array reads passed through from a storage port, reads from a parameter-defined capability table, or reads of the maker and part identifiers. It is used to check a host-side probe sequencer end to end. The sequencer can find the table signature, walk the table, read the identifiers and put the device back into array mode, all against a real state machine instead of a canned response.

Bus addresses are scaled down to device word addresses by a right shift that a parameter sets. This models a part sitting on a bus wider than its own data. All command decoding and table lookup use the word address. The model has no program or erase engine, no status polling and no cell timing.

Top module: `flash_cmd_responder`

## Requirements
- R1: After reset the block is in array mode. `bus_rdata` equals `arr_rdata`, and `arr_addr` carries the word address.
- R2: A write of data 0xF0 or 0xFF at any address puts the block into array mode from the next cycle, whatever mode it was in.
- R3: A write of 0x98 at word address 0x55 enters query mode. A write of 0x98 at any other word address leaves the mode unchanged.
- R4: In query mode, word addresses 0x10, 0x11 and 0x12 read 0x51, 0x52 and 0x59 (ASCII Q, R, Y). Word 0x10+i reads byte i of the table parameter for i in 0..47. Every other word reads zero.
- R5: In the default table, word 0x2C holds the number of erase regions, which is 2. Each region has a four-byte descriptor starting at word 0x2D, least significant byte first. The low 16 bits hold the block count minus one and the high 16 bits hold the block size divided by 256. Region 0 is 8 blocks of 8 KiB and region 1 is 31 blocks of 64 KiB.
- R6: In the default table, timeouts are stored as base-2 exponents. The maximum field is a further exponent on top of the typical value. The words are: single-write typical 0x1F = 4, single-write maximum 0x23 = 3, block-erase typical 0x21 = 10 and block-erase maximum 0x25 = 4.
- R7: Identifier mode is entered only after three writes in a row: 0xAA at word 0x555, then 0x55 at word 0x2AA, then 0x90 at word 0x555. In that mode, word 0 reads the manufacturer parameter, word 1 reads the device parameter and every other word reads zero.
- R8: A write that does not match the next expected unlock step returns the unlock progress to its start. It does not change the current mode, so a later partial sequence cannot complete.
- R9: A write that is neither a reset, a query entry nor a completed unlock leaves the mode unchanged. An example is 0x90 at word 0x555 with no unlock before it.
- R10: Word address = bus address shifted right by `SCALE_LOG2`, and the low bits are ignored. With `SCALE_LOG2` = 1, a command at bus address 0x55 is not a query entry, and bus address 0xAB is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per command write |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | DATA_W | Write data; the low 8 bits are the command |
| bus_rdata | output | DATA_W | Read data for the current address and mode |
| arr_addr | output | ADDR_W-SCALE_LOG2 | Word address to the storage array |
| arr_rdata | input | DATA_W | Data returned by the storage array |

## Verification
The mode register and the unlock progress are not visible at the ports. A wrong value in either shows up only through what a read returns. The bench therefore follows every command write with reads at addresses whose answer is different in each of the three modes. Word 0x10 gives array data, 0x51 or zero, and word 0 gives array data, zero or the maker code. A mode that was entered wrongly, or not entered, is seen on the first read after the write. An unlock state that was not cleared is seen only when later writes would complete the sequence. For that reason the abort tests finish the sequence afterwards and then read word 0.

// File: rtl/flash_resp_pkg.sv
// Shared types, command codes and the default capability table for the
// flash command-mode responder. Assumes 8-bit command codes.
package flash_resp_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_QUERY = 2'd1,
        MODE_IDENT = 2'd2
    } flash_mode_e;

    typedef enum logic [1:0] {
        UL_IDLE   = 2'd0,
        UL_FIRST  = 2'd1,
        UL_SECOND = 2'd2
    } unlock_e;

    localparam int QT_BASE = 16;
    localparam int QT_LEN  = 48;

    localparam logic [7:0] CMD_RESET_A = 8'hF0;
    localparam logic [7:0] CMD_RESET_B = 8'hFF;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_UL1     = 8'hAA;
    localparam logic [7:0] CMD_UL2     = 8'h55;
    localparam logic [7:0] CMD_IDENT   = 8'h90;

    localparam int ADR_QUERY = 'h55;
    localparam int ADR_UL_A  = 'h555;
    localparam int ADR_UL_B  = 'h2AA;

    // Builds the default table image; byte i answers word QT_BASE+i.
    function automatic logic [QT_LEN*8-1:0] default_table();
        logic [QT_LEN*8-1:0] t;
        t = '0;
        t[8*0  +: 8] = 8'h51;   // signature
        t[8*1  +: 8] = 8'h52;
        t[8*2  +: 8] = 8'h59;
        t[8*3  +: 8] = 8'h02;   // primary command set
        t[8*5  +: 8] = 8'h40;   // primary extension location
        t[8*11 +: 8] = 8'h27;   // supply min
        t[8*12 +: 8] = 8'h36;   // supply max
        t[8*15 +: 8] = 8'h04;   // single write typ exponent (word 0x1F)
        t[8*17 +: 8] = 8'h0A;   // block erase typ exponent (word 0x21)
        t[8*19 +: 8] = 8'h03;   // single write max exponent (word 0x23)
        t[8*21 +: 8] = 8'h04;   // block erase max exponent (word 0x25)
        t[8*23 +: 8] = 8'h15;   // log2 size: 2 MiB
        t[8*24 +: 8] = 8'h01;   // bus width code
        t[8*28 +: 8] = 8'h02;   // erase region count (word 0x2C)
        t[8*29 +: 8] = 8'h07;   // region 0: 8 blocks
        t[8*31 +: 8] = 8'h20;   // region 0: 8 KiB / 256
        t[8*33 +: 8] = 8'h1E;   // region 1: 31 blocks
        t[8*36 +: 8] = 8'h01;   // region 1: 64 KiB / 256 = 0x100
        return t;
    endfunction

endpackage

// File: rtl/flash_unlock_seq.sv
// Tracks the three-write unlock sequence for identifier mode.
// Assumes one write per strobe cycle; any mismatching write restarts it.
module flash_unlock_seq
    import flash_resp_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] word_addr,
    input  logic [7:0]        cmd,
    output logic              id_grant
);

    unlock_e state;
    logic    step_ok;

    // Decides whether the current write is the next expected unlock step.
    always_comb begin
        case (state)
            UL_IDLE:   step_ok = (cmd == CMD_UL1)   && (word_addr == WORD_W'(ADR_UL_A));
            UL_FIRST:  step_ok = (cmd == CMD_UL2)   && (word_addr == WORD_W'(ADR_UL_B));
            UL_SECOND: step_ok = (cmd == CMD_IDENT) && (word_addr == WORD_W'(ADR_UL_A));
            default:   step_ok = 1'b0;
        endcase
    end

    assign id_grant = wr_stb && step_ok && (state == UL_SECOND);

    // Advances on a matching write, falls back to idle on any other write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= UL_IDLE;
        end else if (wr_stb) begin
            if (!step_ok) begin
                state <= UL_IDLE;
            end else begin
                case (state)
                    UL_IDLE:  state <= UL_FIRST;
                    UL_FIRST: state <= UL_SECOND;
                    default:  state <= UL_IDLE;
                endcase
            end
        end
    end

    // R8: a wrong write part way through drops progress to idle
    p_abort_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != UL_IDLE && wr_stb && !step_ok) |=> (state == UL_IDLE));

    // R9: progress only moves on writes
    p_hold_without_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(state));

endmodule

// File: rtl/flash_mode_fsm.sv
// Holds the responder's read mode and applies reset, query-entry and
// identifier-entry commands. Reset codes win over every other command.
module flash_mode_fsm
    import flash_resp_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] word_addr,
    input  logic [7:0]        cmd,
    input  logic              id_grant,
    output flash_mode_e       mode
);

    logic is_reset_cmd;
    logic is_query_cmd;

    // Classifies the current write.
    always_comb begin
        is_reset_cmd = (cmd == CMD_RESET_A) || (cmd == CMD_RESET_B);
        is_query_cmd = (cmd == CMD_QUERY) && (word_addr == WORD_W'(ADR_QUERY));
    end

    // Updates the mode register on recognised commands only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_ARRAY;
        end else if (wr_stb) begin
            if (is_reset_cmd)      mode <= MODE_ARRAY;
            else if (is_query_cmd) mode <= MODE_QUERY;
            else if (id_grant)     mode <= MODE_IDENT;
        end
    end

    // R2: either reset code returns to array mode
    p_reset_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (cmd == 8'hF0 || cmd == 8'hFF)) |=> (mode == MODE_ARRAY));

    // R3: query entry at the magic word address
    p_query_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cmd == 8'h98 && word_addr == WORD_W'('h55)) |=> (mode == MODE_QUERY));

    // R7: identifier mode only follows a completed unlock
    p_ident_after_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDENT && $past(mode) != MODE_IDENT) |-> $past(id_grant));

    // R9: mode holds without writes
    p_mode_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(mode));

endmodule

// File: rtl/flash_read_mux.sv
// Selects read data for the current mode: array port, table image or
// identifier codes. Purely combinational; assumes DATA_W >= 8.
module flash_read_mux
    import flash_resp_pkg::*;
#(
    parameter int                  WORD_W      = 16,
    parameter int                  DATA_W      = 8,
    parameter logic [DATA_W-1:0]   MFR_CODE    = '0,
    parameter logic [DATA_W-1:0]   DEV_CODE    = '0,
    parameter logic [QT_LEN*8-1:0] QUERY_IMAGE = '0
) (
    input  flash_mode_e       mode,
    input  logic [WORD_W-1:0] word_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = $clog2(QT_LEN);

    logic             in_table;
    logic [IDX_W-1:0] qidx;
    logic [7:0]       qbyte;

    // Finds the table byte for the current word address.
    always_comb begin
        in_table = (word_addr >= WORD_W'(QT_BASE)) && (word_addr < WORD_W'(QT_BASE + QT_LEN));
        qidx     = IDX_W'(word_addr - WORD_W'(QT_BASE));
        qbyte    = in_table ? QUERY_IMAGE[{qidx, 3'b000} +: 8] : 8'h00;
    end

    // Drives the read data according to mode.
    always_comb begin
        case (mode)
            MODE_ARRAY: rdata = arr_rdata;
            MODE_QUERY: rdata = DATA_W'(qbyte);
            MODE_IDENT: begin
                if (word_addr == WORD_W'(0))      rdata = MFR_CODE;
                else if (word_addr == WORD_W'(1)) rdata = DEV_CODE;
                else                              rdata = '0;
            end
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/flash_cmd_responder.sv
// Top of the flash command-mode responder. Scales the bus address to a
// word address, tracks the unlock sequence and mode, and muxes read data.
// Assumes single-cycle write strobes and SCALE_LOG2 < ADDR_W - 11.
module flash_cmd_responder
    import flash_resp_pkg::*;
#(
    parameter int                  ADDR_W      = 16,
    parameter int                  DATA_W      = 8,
    parameter int                  SCALE_LOG2  = 0,
    parameter logic [DATA_W-1:0]   MFR_CODE    = DATA_W'(8'h89),
    parameter logic [DATA_W-1:0]   DEV_CODE    = DATA_W'(8'h7E),
    parameter logic [QT_LEN*8-1:0] QUERY_IMAGE = default_table()
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic [ADDR_W-SCALE_LOG2-1:0] arr_addr,
    input  logic [DATA_W-1:0]            arr_rdata
);

    localparam int WORD_W = ADDR_W - SCALE_LOG2;

    logic [WORD_W-1:0] word_addr;
    logic [7:0]        cmd;
    logic              id_grant;
    flash_mode_e       mode;

    assign word_addr = bus_addr[ADDR_W-1:SCALE_LOG2];
    assign cmd       = bus_wdata[7:0];
    assign arr_addr  = word_addr;

    flash_unlock_seq #(.WORD_W(WORD_W)) u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (bus_we),
        .word_addr (word_addr),
        .cmd       (cmd),
        .id_grant  (id_grant)
    );

    flash_mode_fsm #(.WORD_W(WORD_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (bus_we),
        .word_addr (word_addr),
        .cmd       (cmd),
        .id_grant  (id_grant),
        .mode      (mode)
    );

    flash_read_mux #(
        .WORD_W      (WORD_W),
        .DATA_W      (DATA_W),
        .MFR_CODE    (MFR_CODE),
        .DEV_CODE    (DEV_CODE),
        .QUERY_IMAGE (QUERY_IMAGE)
    ) u_rmux (
        .mode      (mode),
        .word_addr (word_addr),
        .arr_rdata (arr_rdata),
        .rdata     (bus_rdata)
    );

    // R1: array mode passes storage data straight through
    p_array_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ARRAY) |-> (bus_rdata == arr_rdata));

endmodule

// File: tb/test_flash_cmd_responder.sv
// Directed bench for the flash command-mode responder, run with address
// scaling of 2 (SCALE_LOG2 = 1).
module test_flash_cmd_responder;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SC     = 1;
    localparam logic [7:0] MFR = 8'h1C;
    localparam logic [7:0] DEV = 8'h3D;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [ADDR_W-SC-1:0] arr_addr;
    logic [DATA_W-1:0] arr_rdata;

    int checks = 0;
    int errors = 0;

    always #2.5ns clk = ~clk;

    assign arr_rdata = arr_addr[7:0] ^ 8'hA5;

    flash_cmd_responder #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCALE_LOG2(SC),
        .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) i_flash_cmd_responder (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .arr_addr(arr_addr), .arr_rdata(arr_rdata)
    );

    function automatic logic [7:0] arr_exp(int w);
        return 8'(w) ^ 8'hA5;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr_raw(logic [ADDR_W-1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic wr_word(int w, logic [7:0] d);
        wr_raw(ADDR_W'(w << SC), d);
    endtask

    task automatic rd_word(int w, output logic [7:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(w << SC);
        #1ns;
        d = bus_rdata;
    endtask

    task automatic unlock_ident();
        wr_word('h555, 8'hAA);
        wr_word('h2AA, 8'h55);
        wr_word('h555, 8'h90);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        rd_word('h10, d); check("R1 array read after reset", d, arr_exp('h10));
        rd_word('h123, d); check("R1 array read other word", d, arr_exp('h123));
        check("R1 arr_addr is word address", 32'(arr_addr), 32'h123);
    endtask

    task automatic t_query_sig();
        logic [7:0] d;
        wr_word('h55, 8'h98);
        rd_word('h10, d); check("R3 query entered / R4 Q", d, 8'h51);
        rd_word('h11, d); check("R4 R", d, 8'h52);
        rd_word('h12, d); check("R4 Y", d, 8'h59);
        rd_word('h0F, d); check("R4 below table reads zero", d, 8'h00);
        rd_word('h40, d); check("R4 above table reads zero", d, 8'h00);
    endtask

    task automatic t_regions();
        logic [7:0] d;
        int cnt0 = 8, sz0 = 8192, cnt1 = 31, sz1 = 65536;
        logic [31:0] desc0, desc1;
        desc0 = {16'(sz0 / 256), 16'(cnt0 - 1)};
        desc1 = {16'(sz1 / 256), 16'(cnt1 - 1)};
        rd_word('h2C, d); check("R5 region count", d, 8'd2);
        for (int i = 0; i < 4; i++) begin
            rd_word('h2D + i, d); check("R5 region0 byte", d, desc0[8*i +: 8]);
            rd_word('h31 + i, d); check("R5 region1 byte", d, desc1[8*i +: 8]);
        end
    endtask

    task automatic t_timeouts();
        logic [7:0] d;
        rd_word('h1F, d); check("R6 write typ exp", d, 8'd4);
        rd_word('h23, d); check("R6 write max exp", d, 8'd3);
        rd_word('h21, d); check("R6 erase typ exp", d, 8'd10);
        rd_word('h25, d); check("R6 erase max exp", d, 8'd4);
    endtask

    task automatic t_reset_codes();
        logic [7:0] d;
        wr_word('h000, 8'hF0);
        rd_word('h10, d); check("R2 F0 leaves query", d, arr_exp('h10));
        unlock_ident();
        rd_word(0, d); check("R7 ident entered", d, MFR);
        wr_word('h777, 8'hFF);
        rd_word(0, d); check("R2 FF leaves ident", d, arr_exp(0));
    endtask

    task automatic t_ident();
        logic [7:0] d;
        unlock_ident();
        rd_word(0, d); check("R7 maker code", d, MFR);
        rd_word(1, d); check("R7 device code", d, DEV);
        rd_word(2, d); check("R7 other word zero", d, 8'h00);
        wr_word('h55, 8'h98);
        rd_word('h10, d); check("R3 query from ident", d, 8'h51);
        wr_word(0, 8'hF0);
    endtask

    task automatic t_unlock_abort();
        logic [7:0] d;
        wr_word('h555, 8'hAA);
        wr_word('h2AA, 8'h55);
        wr_word('h123, 8'h12);
        wr_word('h555, 8'h90);
        rd_word(0, d); check("R8 abort at third step", d, arr_exp(0));
        wr_word('h555, 8'hAA);
        wr_word('h2AB, 8'h55);
        wr_word('h2AA, 8'h55);
        wr_word('h555, 8'h90);
        rd_word(0, d); check("R8 abort at second step", d, arr_exp(0));
        wr_word('h55, 8'h98);
        wr_word('h555, 8'hAA);
        wr_word('h000, 8'h00);
        rd_word('h10, d); check("R8 abort keeps query mode", d, 8'h51);
        wr_word('h2AA, 8'h55);
        wr_word('h555, 8'h90);
        rd_word(0, d); check("R8 no ident after abort", d, 8'h00);
        wr_word(0, 8'hF0);
    endtask

    task automatic t_stray();
        logic [7:0] d;
        wr_word('h555, 8'h90);
        rd_word(0, d); check("R9 lone 0x90 ignored", d, arr_exp(0));
        wr_word('h56, 8'h98);
        rd_word('h10, d); check("R3 0x98 at wrong word ignored", d, arr_exp('h10));
        wr_word('h55, 8'h98);
        wr_word('h12, 8'h00);
        rd_word('h10, d); check("R9 stray write keeps query", d, 8'h51);
        wr_word(0, 8'hFF);
    endtask

    task automatic t_scaling();
        logic [7:0] d;
        wr_raw(16'h0055, 8'h98);
        rd_word('h10, d); check("R10 unscaled 0x55 not query", d, arr_exp('h10));
        wr_raw(16'h00AB, 8'h98);
        rd_word('h10, d); check("R10 byte 0xAB enters query", d, 8'h51);
        wr_raw(16'h0001, 8'hF0);
        @(negedge clk); bus_addr = 16'h1235; #1ns;
        check("R10 arr_addr drops low bit", 32'(arr_addr), 32'h091A);
        check("R10 array data at scaled word", bus_rdata, arr_exp('h091A));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_query_sig();
        t_regions();
        t_timeouts();
        t_reset_codes();
        t_ident();
        t_unlock_abort();
        t_stray();
        t_scaling();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1ms;
        checks++;
        errors++;
        $display("FAIL watchdog R1..: run did not finish, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule